// File: doc/BRIEF.md
# Power-Fail Memory Enable Guard

This block sits between a host's active-low memory chip-enable and a set of SRAM banks. In normal running it passes the enable to exactly one bank, chosen by a binary bank index. All other bank enables stay inactive (high). Two status inputs describe the supply: a failure flag from an external comparator and a power-good level. When either input reports trouble, every bank enable is forced high, so the memory cannot be written while the supply is out of tolerance.

The block does not cut off an access that has already started. If the enable is low when trouble is seen, the access may run on until the host releases the enable. It may not run longer than a bounded write-protect window, counted in clock ticks; when the window ends, the outputs go high anyway. When the supply comes back, a recovery lockout of a fixed number of ticks holds every output high, whatever the enable does, so the host has time to settle. If the supply fails again during that lockout, the block goes back to protection and the lockout starts over in full.

The chip-enable, the failure flag and the power-good level are asynchronous, and each passes through a two-flop synchronizer. The bank index is taken as synchronous to the clock. A write-protect status output is high whenever the memory is locked out. It is low during the short window in which an interrupted access is allowed to finish.

Top module: `pfce_guard`

## Requirements
- R1: While the supply is healthy and the lockout is over, output bit `bank_sel` (value k drives bit k) equals `ce_n_in` as seen after two clock edges of synchronization, and every other output bit is 1. At most one output bit is ever low.
- R2: A supply fault is the failure flag high or the power-good level low. A fault seen while no access is active forces all outputs to 1 within three clock edges. The outputs stay 1 for any later `ce_n_in` value.
- R3: If `ce_n_in` is low when a fault is seen, the selected output keeps following the enable until the enable goes high. After that all outputs are 1, and a new low on `ce_n_in` has no effect.
- R4: An access that is still running is cut off. Counting from the edge that first sees the fault, the selected output stays low for `WPT_TICKS` further clock edges and is forced to 1 at the next one.
- R5: Once the fault clears, counting from the edge that first sees the clean supply, all outputs stay 1 for `REC_TICKS` further edges, whatever `ce_n_in` is. At the next edge normal following resumes.
- R6: A fault seen during the recovery lockout returns the block to protection. A later clean supply starts a full `REC_TICKS` lockout again.
- R7: Reset puts the block in protection: all outputs are 1 and `wr_protected` is 1. The outputs stay that way until the supply is seen clean and a full recovery lockout has passed.
- R8: `wr_protected` is 1 during protection and during the recovery lockout. It is 0 during normal following and during the window in which an interrupted access is allowed to finish.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock for synchronizers and tick counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n_in | input | 1 | Host chip-enable, active low, asynchronous |
| pfail_in | input | 1 | Supply failure flag from an external comparator, high means failed, asynchronous |
| pgood_in | input | 1 | Supply good level, high means good, asynchronous |
| bank_sel | input | SEL_W (2) | Binary index of the bank that receives the enable |
| ce_n_out | output | N_BANKS (4) | Conditioned per-bank chip-enables, active low |
| wr_protected | output | 1 | High while the memory is locked out (protection or recovery) |

## Verification
The bench builds the block with `WPT_TICKS` = 5 and `REC_TICKS` = 12 in place of the default values, which are hundreds and millions of ticks. With these small values the exact edge on which each window closes is inside the run. The bench samples the last edge before each window ends and the first edge after it, so an off-by-one in either counter, or in the synchronizer depth, shows up as a wrong output. A fault injected partway through the lockout shows that the recovery count really restarts.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_FINISH  = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfce_state_e;

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pfce_down_counter.sv
module pfce_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (en && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pfce_bank_gate.sv
module pfce_bank_gate #(
  parameter int N_BANKS = 4,
  parameter int SEL_W   = 2
) (
  input  logic               pass,
  input  logic               ce_n,
  input  logic [SEL_W-1:0]   sel,
  output logic [N_BANKS-1:0] ce_n_out
);

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    assign ce_n_out[g] = ~(pass & ~ce_n & (sel == SEL_W'(g)));
  end

endmodule

// File: rtl/pfce_guard.sv
module pfce_guard
  import pfce_pkg::*;
#(
  parameter int N_BANKS     = 4,
  parameter int SEL_W       = $clog2(N_BANKS),
  parameter int SYNC_STAGES = 2,
  parameter int WPT_TICKS   = 500,
  parameter int REC_TICKS   = 6_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n_in,
  input  logic               pfail_in,
  input  logic               pgood_in,
  input  logic [SEL_W-1:0]   bank_sel,
  output logic [N_BANKS-1:0] ce_n_out,
  output logic               wr_protected
);

  localparam int WPT_W = $clog2(WPT_TICKS + 1);
  localparam int REC_W = $clog2(REC_TICKS + 1);
  localparam logic [WPT_W-1:0] WPT_LOAD = WPT_W'(WPT_TICKS - 1);
  localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_TICKS - 1);

  logic [2:0]  sync_q;
  logic        ce_s, pf_s, pg_s, fail_s;
  pfce_state_e st_q, st_d;
  logic        wpt_load, rec_load, wpt_zero, rec_zero, pass;

  // Asynchronous inputs, reset to "enable off, supply bad".
  pfce_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ce_n_in, pfail_in, pgood_in}),
    .q    (sync_q)
  );

  assign {ce_s, pf_s, pg_s} = sync_q;
  assign fail_s = pf_s | ~pg_s;

  always_comb begin
    st_d     = st_q;
    wpt_load = 1'b0;
    rec_load = 1'b0;
    unique case (st_q)
      ST_NORMAL: begin
        if (fail_s) begin
          if (!ce_s) begin
            st_d     = ST_FINISH;
            wpt_load = 1'b1;
          end else begin
            st_d = ST_PROTECT;
          end
        end
      end
      ST_FINISH: begin
        if (ce_s || wpt_zero) st_d = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (!fail_s) begin
          st_d     = ST_RECOVER;
          rec_load = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (fail_s)        st_d = ST_PROTECT;
        else if (rec_zero) st_d = ST_NORMAL;
      end
      default: st_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PROTECT;
    else        st_q <= st_d;
  end

  pfce_down_counter #(.W(WPT_W)) u_wpt_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wpt_load),
    .load_val(WPT_LOAD),
    .en      (st_q == ST_FINISH),
    .zero    (wpt_zero)
  );

  pfce_down_counter #(.W(REC_W)) u_rec_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rec_load),
    .load_val(REC_LOAD),
    .en      (st_q == ST_RECOVER),
    .zero    (rec_zero)
  );

  assign pass         = (st_q == ST_NORMAL) || (st_q == ST_FINISH);
  assign wr_protected = (st_q == ST_PROTECT) || (st_q == ST_RECOVER);

  pfce_bank_gate #(
    .N_BANKS(N_BANKS),
    .SEL_W  (SEL_W)
  ) u_gate (
    .pass    (pass),
    .ce_n    (ce_s),
    .sel     (bank_sel),
    .ce_n_out(ce_n_out)
  );

endmodule

// File: rtl/pfce_guard_chk.sv
module pfce_guard_chk
  import pfce_pkg::*;
#(
  parameter int N_BANKS   = 4,
  parameter int WPT_TICKS = 500,
  parameter int REC_TICKS = 6_000_000
) (
  input logic               clk,
  input logic               rst_n,
  input pfce_state_e        st,
  input logic               fail_s,
  input logic               ce_s,
  input logic [N_BANKS-1:0] ce_n_out,
  input logic               wr_protected
);

  localparam int LW = $clog2(REC_TICKS + WPT_TICKS + 2) + 1;

  logic [LW-1:0] fin_len, rec_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_len <= '0;
      rec_len <= '0;
    end else begin
      fin_len <= (st == ST_FINISH)  ? fin_len + 1'b1 : '0;
      rec_len <= (st == ST_RECOVER) ? rec_len + 1'b1 : '0;
    end
  end

  a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n_out) <= 1);

  a_r2_locked_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protected |-> (&ce_n_out));

  a_r2_fault_leaves_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORMAL && fail_s) |=> (st != ST_NORMAL));

  a_r3_release_protects: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FINISH && ce_s) |=> (st == ST_PROTECT));

  a_r4_finish_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FINISH) |-> (int'(fin_len) < WPT_TICKS));

  a_r5_full_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORMAL && $past(st) == ST_RECOVER) |-> (int'(rec_len) == REC_TICKS));

  a_r6_fault_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOVER && fail_s) |=> (st == ST_PROTECT));

endmodule

bind pfce_guard pfce_guard_chk #(
  .N_BANKS  (N_BANKS),
  .WPT_TICKS(WPT_TICKS),
  .REC_TICKS(REC_TICKS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .st          (st_q),
  .fail_s      (fail_s),
  .ce_s        (ce_s),
  .ce_n_out    (ce_n_out),
  .wr_protected(wr_protected)
);

// File: tb/pfce_guard_tb.sv
module pfce_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WPT = 5;
  localparam int REC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n_in = 1'b1;
  logic       pfail_in = 1'b0;
  logic       pgood_in = 1'b1;
  logic [1:0] bank_sel = 2'd0;
  logic [3:0] ce_n_out;
  logic       wr_protected;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfce_guard #(
    .N_BANKS  (4),
    .WPT_TICKS(WPT),
    .REC_TICKS(REC)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n_in     (ce_n_in),
    .pfail_in    (pfail_in),
    .pgood_in    (pgood_in),
    .bank_sel    (bank_sel),
    .ce_n_out    (ce_n_out),
    .wr_protected(wr_protected)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] exp_out, input logic exp_wp);
    n_checks++;
    if (ce_n_out !== exp_out || wr_protected !== exp_wp) begin
      n_fail++;
      $display("FAIL %s: ce_n_out=%b wr_protected=%b, expected %b / %b",
               req, ce_n_out, wr_protected, exp_out, exp_wp);
    end
  endtask

  function automatic logic [3:0] one_low(input int k);
    return ~(4'b0001 << k);
  endfunction

  task automatic power_up();
    pfail_in = 1'b0;
    pgood_in = 1'b1;
    cyc(3 + REC);
  endtask

  // R7, R5: reset state, then exact lockout length after release
  task automatic t_reset();
    ce_n_in = 1'b0; bank_sel = 2'd2;
    cyc(2);
    chk("R7 in reset", 4'b1111, 1'b1);
    rst_n = 1'b1;
    chk("R7 after release", 4'b1111, 1'b1);
    cyc(2 + REC);
    chk("R5 last lockout edge", 4'b1111, 1'b1);
    cyc(1);
    chk("R5 lockout over", 4'b1011, 1'b0);
  endtask

  // R1: follow on each bank with two-edge latency; R8 low in normal
  task automatic t_normal();
    for (int s = 0; s < 4; s++) begin
      ce_n_in = 1'b1; bank_sel = 2'(s);
      cyc(3);
      chk("R1 idle", 4'b1111, 1'b0);
      ce_n_in = 1'b0;
      cyc(1);
      chk("R1 one edge not yet", 4'b1111, 1'b0);
      cyc(1);
      chk("R1 follow", one_low(s), 1'b0);
      bank_sel = 2'((s + 1) % 4);
      #1;
      chk("R1 bank move", one_low((s + 1) % 4), 1'b0);
      @(negedge clk);
    end
    ce_n_in = 1'b1;
    cyc(3);
  endtask

  // R2: fault flag with no access, later enable ignored
  task automatic t_fail_idle();
    ce_n_in = 1'b1; bank_sel = 2'd1;
    pfail_in = 1'b1;
    cyc(3);
    chk("R2 fault idle", 4'b1111, 1'b1);
    ce_n_in = 1'b0;
    cyc(3);
    chk("R2 enable ignored", 4'b1111, 1'b1);
    power_up();
    chk("R5 back to normal", 4'b1101, 1'b0);
    ce_n_in = 1'b1;
    cyc(3);
  endtask

  // R2: power-good low alone is a fault
  task automatic t_pgood_drop();
    bank_sel = 2'd0;
    pgood_in = 1'b0;
    cyc(3);
    chk("R2 pgood low", 4'b1111, 1'b1);
    ce_n_in = 1'b0;
    cyc(3);
    chk("R2 pgood enable ignored", 4'b1111, 1'b1);
    power_up();
    ce_n_in = 1'b1;
    cyc(3);
  endtask

  // R3, R8: interrupted access finishes on enable release
  task automatic t_finish_release();
    bank_sel = 2'd1; ce_n_in = 1'b0;
    cyc(3);
    chk("R1 pre-fault access", 4'b1101, 1'b0);
    pfail_in = 1'b1;
    cyc(3);
    chk("R3 access continues", 4'b1101, 1'b0);
    chk("R8 low while finishing", 4'b1101, 1'b0);
    ce_n_in = 1'b1;
    cyc(3);
    chk("R3 protected after release", 4'b1111, 1'b1);
    ce_n_in = 1'b0;
    cyc(3);
    chk("R3 new access ignored", 4'b1111, 1'b1);
    power_up();
    ce_n_in = 1'b1;
    cyc(3);
  endtask

  // R4: access held past the window is cut off on the exact edge
  task automatic t_finish_timeout();
    bank_sel = 2'd3; ce_n_in = 1'b0;
    cyc(3);
    chk("R1 pre-fault access", 4'b0111, 1'b0);
    pfail_in = 1'b1;
    cyc(2 + WPT);
    chk("R4 last allowed edge", 4'b0111, 1'b0);
    cyc(1);
    chk("R4 forced off", 4'b1111, 1'b1);
  endtask

  // R6: fault during lockout restarts it in full
  task automatic t_recovery_restart();
    bank_sel = 2'd0; ce_n_in = 1'b0;
    pfail_in = 1'b0;
    cyc(6);
    chk("R5 in lockout", 4'b1111, 1'b1);
    pfail_in = 1'b1;
    cyc(4);
    chk("R6 back to protect", 4'b1111, 1'b1);
    pfail_in = 1'b0;
    cyc(2 + REC);
    chk("R6 full lockout again", 4'b1111, 1'b1);
    cyc(1);
    chk("R6 lockout over", 4'b1110, 1'b0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_fail_idle();
    t_pgood_drop();
    t_finish_release();
    t_finish_timeout();
    t_recovery_restart();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule